// File: doc/BRIEF.md
# Comparator Status and Interrupt Logic

This block is the digital wrapper around an analog voltage comparator. The comparator's raw output arrives with no relation to the clock. The block passes it through a short synchronizer and watches the synchronized level for a chosen kind of change. When that change occurs, a sticky flag is set. The flag, combined with a local enable and a chip-wide interrupt enable, drives an interrupt request.

Software reaches the block through one 8-bit control/status register with a simple write strobe and a continuous read port. The same register supplies three controls for the analog side:
- a power-down line,
- a select line that chooses between the internal reference and the external pin as the positive input,
- a gate that routes the synchronized comparator level to a timer capture trigger.

Setting the power-down bit also stops event detection, so switching the comparator off or on cannot raise a false interrupt.

Top module: `cmp_ctrl_status`

## Requirements
- R1: After reset, every register bit reads 0, and `irq`, `cap_trig`, `pwr_down` and `ref_sel` are all 0.
- R2: Bits 7, 6, 3, 2, 1 and 0 are written by `wr_en` and read back unchanged. Bit 7 drives `pwr_down`. Bit 6 drives `ref_sel` (1 = internal reference, 0 = external pin).
- R3: Bit 5 is read-only and returns the synchronized comparator level. A change on `cmp_raw` that is set up before a rising clock edge becomes visible after the second rising edge. Writing bit 5 has no effect.
- R4: When bits 1:0 = 00, either a rising or a falling change of the synchronized level sets the flag (bit 4). The flag is set on the rising edge after the change shows up in bit 5.
- R5: When bits 1:0 = 11, only a rising change sets the flag.
- R6: When bits 1:0 = 10, only a falling change sets the flag.
- R7: When bits 1:0 = 01, no change sets the flag.
- R8: Writing 1 to bit 4 clears the flag. Writing 0 to bit 4 leaves the flag unchanged.
- R9: A one-cycle `irq_ack` pulse clears the flag.
- R10: `irq` is 1 exactly when the flag, the enable bit 3 and the `gie` input are all 1.
- R11: While bit 2 is 1, `cap_trig` follows the synchronized level. While bit 2 is 0, `cap_trig` is 0.
- R12: While bit 7 is 1, no comparator change sets the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmp_raw | input | 1 | Asynchronous comparator output |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read data |
| gie | input | 1 | Global interrupt enable |
| irq_ack | input | 1 | Interrupt acknowledge pulse |
| irq | output | 1 | Interrupt request |
| cap_trig | output | 1 | Trigger toward timer input capture |
| ref_sel | output | 1 | Positive input select, 1 = internal reference |
| pwr_down | output | 1 | Comparator power-down |

## Verification
The bench checks the flag one edge before and exactly on the edge it should set. A synchronizer with a stage too many or too few, or edge detection on the wrong stage pair, would set the flag a cycle off. Each mode is driven with both polarities of change, which catches swapped rising/falling decodes and a reserved code that still reacts. Writing 0 to the flag while it is set catches a design that clears on any write. A write that sets bit 5 catches a read-only bit that is actually stored. Toggling the input while the disable bit is set, and then clearing the bit, catches a design that records events while powered down or on re-enable.

// File: rtl/cmp_ctrl_status.sv
module cmp_ctrl_status #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmp_raw,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic       gie,
  input  logic       irq_ack,
  output logic       irq,
  output logic       cap_trig,
  output logic       ref_sel,
  output logic       pwr_down
);

  localparam logic [1:0] MODE_ANY  = 2'b00;
  localparam logic [1:0] MODE_FALL = 2'b10;
  localparam logic [1:0] MODE_RISE = 2'b11;

  logic [SYNC_STAGES:0] sh;
  logic       dis, rsel, flag, ien, cap_en;
  logic [1:0] mode;
  logic       sync_lvl, prev_lvl, evt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sh <= '0;
    else        sh <= {sh[SYNC_STAGES-1:0], cmp_raw};

  assign sync_lvl = sh[SYNC_STAGES-1];
  assign prev_lvl = sh[SYNC_STAGES];

  always_comb begin
    unique case (mode)
      MODE_ANY:  evt = sync_lvl ^ prev_lvl;
      MODE_FALL: evt = prev_lvl & ~sync_lvl;
      MODE_RISE: evt = sync_lvl & ~prev_lvl;
      default:   evt = 1'b0;
    endcase
    if (dis) evt = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      {dis, rsel, ien, cap_en} <= '0;
      mode <= '0;
    end else if (wr_en) begin
      {dis, rsel} <= wr_data[7:6];
      {ien, cap_en, mode} <= wr_data[3:0];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                              flag <= 1'b0;
    else if (evt)                            flag <= 1'b1;
    else if (irq_ack || (wr_en && wr_data[4])) flag <= 1'b0;

  assign rd_data  = {dis, rsel, sync_lvl, flag, ien, cap_en, mode};
  assign irq      = flag & ien & gie;
  assign cap_trig = cap_en & sync_lvl;
  assign ref_sel  = rsel;
  assign pwr_down = dis;

  assert_sync_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[5] == $past(sh[SYNC_STAGES-2]));

  assert_rise_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!dis && mode == MODE_RISE && $rose(sync_lvl)) |=> flag);

  assert_w0_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_data[4] && !irq_ack && flag) |=> flag);

  assert_ack_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !evt) |=> !flag);

  assert_dis_blocks_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (dis && !flag) |=> !flag);

endmodule

// File: tb/cmp_ctrl_status_tb_top.sv
module cmp_ctrl_status_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0, cmp_raw = 0, wr_en = 0, gie = 0, irq_ack = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] rd_data;
  logic irq, cap_trig, ref_sel, pwr_down;
  int checks = 0, failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmp_ctrl_status dut_i (
    .clk(clk), .rst_n(rst_n), .cmp_raw(cmp_raw), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .gie(gie), .irq_ack(irq_ack), .irq(irq), .cap_trig(cap_trig),
    .ref_sel(ref_sel), .pwr_down(pwr_down));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    wr_en = 1; wr_data = d;
    step(1);
    wr_en = 0; wr_data = 0;
  endtask

  task automatic arm(input logic [7:0] cfg);
    wr(cfg); step(1); wr(cfg | 8'h10);
    chk("R8 arm clear", {7'd0, rd_data[4]}, 8'd0);
  endtask

  task automatic drive_and_check(input logic v, input logic exp, input logic [7:0] cfg, input string req);
    cmp_raw = v;
    step(2);
    chk({req, " early"}, {7'd0, rd_data[4]}, 8'd0);
    step(1);
    chk(req, {7'd0, rd_data[4]}, {7'd0, exp});
    wr(cfg | 8'h10);
  endtask

  task automatic t_reset();
    chk("R1 rd", rd_data, 8'h00);
    chk("R1 outs", {4'd0, irq, cap_trig, ref_sel, pwr_down}, 8'h00);
  endtask

  task automatic t_rw();
    wr(8'hFF);
    chk("R2 readback", rd_data, 8'hCF);
    chk("R2 pins", {6'd0, ref_sel, pwr_down}, 8'h03);
    wr(8'h00);
    chk("R2 clear", rd_data, 8'h00);
  endtask

  task automatic t_sync();
    cmp_raw = 1;
    step(1);
    chk("R3 one edge", {7'd0, rd_data[5]}, 8'd0);
    step(1);
    chk("R3 two edges", {7'd0, rd_data[5]}, 8'd1);
    cmp_raw = 0;
    step(3);
    wr(8'h30);
    chk("R3 write ignored", rd_data, 8'h00);
  endtask

  task automatic t_modes();
    arm(8'h00);
    drive_and_check(1, 1, 8'h00, "R4 toggle rise");
    drive_and_check(0, 1, 8'h00, "R4 toggle fall");
    arm(8'h03);
    drive_and_check(1, 1, 8'h03, "R5 rise");
    drive_and_check(0, 0, 8'h03, "R5 fall ignored");
    arm(8'h02);
    drive_and_check(1, 0, 8'h02, "R6 rise ignored");
    drive_and_check(0, 1, 8'h02, "R6 fall");
    arm(8'h01);
    drive_and_check(1, 0, 8'h01, "R7 rise");
    drive_and_check(0, 0, 8'h01, "R7 fall");
  endtask

  task automatic t_w1c();
    arm(8'h00);
    cmp_raw = 1; step(3);
    chk("R8 set", {7'd0, rd_data[4]}, 8'd1);
    wr(8'h00);
    chk("R8 write zero keeps", {7'd0, rd_data[4]}, 8'd1);
    wr(8'h10);
    chk("R8 write one clears", {7'd0, rd_data[4]}, 8'd0);
    cmp_raw = 0; step(3); wr(8'h10);
  endtask

  task automatic t_irq();
    arm(8'h08);
    gie = 0;
    cmp_raw = 1; step(3);
    chk("R10 gie low", {6'd0, rd_data[4], irq}, 8'h02);
    gie = 1; step(1);
    chk("R10 all set", {7'd0, irq}, 8'd1);
    wr(8'h00);
    chk("R10 ie low", {6'd0, rd_data[4], irq}, 8'h02);
    wr(8'h08);
    chk("R10 ie back", {7'd0, irq}, 8'd1);
    irq_ack = 1; step(1); irq_ack = 0;
    chk("R9 ack clears", {6'd0, rd_data[4], irq}, 8'h00);
    gie = 0;
    cmp_raw = 0; step(3); wr(8'h10);
  endtask

  task automatic t_dis();
    arm(8'h80);
    chk("R12 pwr_down", {7'd0, pwr_down}, 8'd1);
    cmp_raw = 1; step(3);
    chk("R12 rise blocked", {7'd0, rd_data[4]}, 8'd0);
    cmp_raw = 0; step(3);
    chk("R12 fall blocked", {7'd0, rd_data[4]}, 8'd0);
    wr(8'h00); step(2);
    chk("R12 re-enable quiet", {7'd0, rd_data[4]}, 8'd0);
  endtask

  task automatic t_cap();
    wr(8'h04);
    chk("R11 low level", {7'd0, cap_trig}, 8'd0);
    cmp_raw = 1; step(1);
    chk("R11 one edge", {7'd0, cap_trig}, 8'd0);
    step(1);
    chk("R11 routed", {7'd0, cap_trig}, 8'd1);
    wr(8'h00);
    chk("R11 gated off", {7'd0, cap_trig}, 8'd0);
    cmp_raw = 0; step(3); wr(8'h10);
  endtask

  initial begin
    step(3);
    rst_n = 1;
    step(1);
    t_reset();
    t_rw();
    t_sync();
    t_modes();
    t_w1c();
    t_irq();
    t_dis();
    t_cap();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    checks++; failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule